// File: doc/BRIEF.md
# DMA Channel Programming Register Bank

This block is the host-side register file of a DMA controller with up to four channels. A host reaches it through an 8-bit I/O port with a 4-bit port address. Each channel keeps a 16-bit start address and a 16-bit transfer count, each held as a base copy and a working copy. Both 16-bit values pass through a single 8-bit port. A byte-pointer flip-flop, shared by all channels, decides whether an access lands on the low byte or the high byte.

Port addresses 0 to 7 reach the channel registers. Ports 8 to 15 carry the control functions:

| Port | Write | Read |
|------|-------|------|
| 0x8 | command | status |
| 0xA | mask or unmask one channel | — |
| 0xB | channel mode | — |
| 0xC | clear the byte pointer | — |
| 0xD | master clear | temporary register |
| 0xE | unmask every channel | — |
| 0xF | load every mask bit at once | — |

The transfer engine sees each channel's enable, its decoded mode fields, and its working address and count. For each transfer it completes, the engine pulses a per-channel step input. The bank then advances the working address and decrements the working count. When a count wraps, the bank records terminal count, and it reloads the channel if the channel is set to auto-initialize.

Top module: `dmac_regbank`

## Requirements
- R1: After reset every channel is masked (`ch_enable` all 0), the byte pointer selects the low byte, and the command output and the status flags are 0. All working and base addresses, counts and modes are also 0.
- R2: Channel c's address sits at port 2c and its count at port 2c+1. A write loads the selected byte into both the base copy and the working copy. A read returns the selected byte of the working copy, and the working values appear on `ch_cur_addr` and `ch_cur_cnt` (channel c at bits 16c+15:16c).
- R3: Every read or write of ports 0 to 7 toggles the byte pointer: low byte first, then high byte. A write of any value to port 0xC returns the pointer to the low byte.
- R4: A write to port 0xA selects a channel with data bits 1:0. Data bit 2 = 1 masks that channel and bit 2 = 0 unmasks it. `ch_enable[c]` is the inverse of channel c's mask.
- R5: A write to port 0xE unmasks every channel. A write to port 0xF loads the masks from data bits 3:0, where bit c = 1 masks channel c.
- R6: A write to port 0xB selects a channel with data bits 1:0 and stores data bits 7:2 as its mode. The fields are: direction = bits 3:2 (01 device-to-memory, 10 memory-to-device), auto-initialize = bit 4, address decrement = bit 5, transfer mode = bits 7:6 (01 single, 11 cascade).
- R7: A write to port 0x8 stores the byte on `ctrl_cmd`. A read of port 0x8 returns the terminal-count flags in bits 3:0 (bit c for channel c) and 0 in bits 7:4. A read also clears those flags, except that a flag set in the same cycle survives.
- R8: A write to port 0xD masks every channel, returns the byte pointer to the low byte, and clears the command and the status flags. Addresses, counts and modes keep their values. A read of port 0xD returns 0.
- R9: A step pulse on an enabled channel decrements its working count by 1. It also moves its working address by +1, or by -1 when address decrement is set. A step taken when the count is 0x0000 sets the channel's terminal-count flag. The count then wraps to 0xFFFF, or, with auto-initialize set, both working copies reload from their base copies. A step on a masked channel changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | Host port address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_rdata | output | 8 | Read data for the addressed port |
| step_i | input | NCH | Per-channel transfer-done pulse from the engine |
| ch_enable | output | NCH | Channel unmasked |
| ch_dir | output | 2*NCH | Per-channel direction field |
| ch_autoinit | output | NCH | Per-channel auto-initialize |
| ch_addr_dec | output | NCH | Per-channel address decrement |
| ch_xfer_mode | output | 2*NCH | Per-channel transfer mode field |
| ch_cur_addr | output | 16*NCH | Working addresses |
| ch_cur_cnt | output | 16*NCH | Working counts |
| ctrl_cmd | output | 8 | Command byte |

## Verification
The bench builds the block with its default of four channels. With four channels, every value of the 2-bit channel select in the mask and mode ports lands on a real channel, and all eight channel register ports are live. It therefore reaches mask and mode writes to the highest channel, byte-pointer sequences that mix reads with writes, and a terminal count on a decrementing, auto-initializing channel. Status flags are checked on two channels, before and after the clearing read.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   localparam int PORT_W = 4;
   localparam int BYTE_W = 8;

   typedef enum logic [PORT_W-1:0] {
      P_CMD_STAT   = 4'h8,
      P_MASK_ONE   = 4'hA,
      P_MODE       = 4'hB,
      P_PTR_CLR    = 4'hC,
      P_MCLR_TEMP  = 4'hD,
      P_UNMASK_ALL = 4'hE,
      P_MASK_ALL   = 4'hF
   } ctl_port_e;

   // stored copy of mode byte bits 7:2
   typedef struct packed {
      logic [1:0] xfer_mode;
      logic       addr_dec;
      logic       auto_init;
      logic [1:0] dir;
   } chan_mode_t;

   typedef struct packed {
      logic cmd_wr;
      logic stat_rd;
      logic mask_one_wr;
      logic mode_wr;
      logic ptr_clr_wr;
      logic mclr_wr;
      logic unmask_all_wr;
      logic mask_all_wr;
   } ctl_strobe_t;

endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
   import dmac_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic [PORT_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   output ctl_strobe_t       strb,
   output logic [NCH-1:0]    addr_wr,
   output logic [NCH-1:0]    cnt_wr,
   output logic              reg_acc
);

   logic is_ctl;

   assign is_ctl  = io_addr[PORT_W-1];
   assign reg_acc = !is_ctl && (io_wr || io_rd);

   always_comb begin
      strb               = '0;
      strb.cmd_wr        = io_wr && (io_addr == P_CMD_STAT);
      strb.stat_rd       = io_rd && (io_addr == P_CMD_STAT);
      strb.mask_one_wr   = io_wr && (io_addr == P_MASK_ONE);
      strb.mode_wr       = io_wr && (io_addr == P_MODE);
      strb.ptr_clr_wr    = io_wr && (io_addr == P_PTR_CLR);
      strb.mclr_wr       = io_wr && (io_addr == P_MCLR_TEMP);
      strb.unmask_all_wr = io_wr && (io_addr == P_UNMASK_ALL);
      strb.mask_all_wr   = io_wr && (io_addr == P_MASK_ALL);
   end

   for (genvar c = 0; c < NCH; c++) begin : g_sel
      logic hit;
      assign hit        = io_wr && !is_ctl && (io_addr[2:1] == 2'(c));
      assign addr_wr[c] = hit && !io_addr[0];
      assign cnt_wr[c]  = hit &&  io_addr[0];
   end

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
   import dmac_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_wr,
   input  logic              cnt_wr,
   input  logic              hi_sel,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              mode_wr,
   input  chan_mode_t        mode_in,
   input  logic              step,
   output logic [REG_W-1:0]  cur_addr,
   output logic [REG_W-1:0]  cur_cnt,
   output chan_mode_t        mode,
   output logic              tc_hit
);

   localparam int HALF = REG_W / 2;

   if (REG_W != 2 * BYTE_W) begin : g_chk_w
      $error("dmac_chan: REG_W must be two bytes wide");
   end

   logic [REG_W-1:0] base_addr, base_cnt;
   logic             at_zero, reload;

   assign at_zero = (cur_cnt == '0);
   assign tc_hit  = step && at_zero;
   assign reload  = tc_hit && mode.auto_init;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr <= '0;
         cur_addr  <= '0;
      end else if (addr_wr) begin
         if (hi_sel) begin
            base_addr[REG_W-1:HALF] <= wdata;
            cur_addr[REG_W-1:HALF]  <= wdata;
         end else begin
            base_addr[HALF-1:0] <= wdata;
            cur_addr[HALF-1:0]  <= wdata;
         end
      end else if (reload) begin
         cur_addr <= base_addr;
      end else if (step) begin
         cur_addr <= mode.addr_dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_cnt <= '0;
         cur_cnt  <= '0;
      end else if (cnt_wr) begin
         if (hi_sel) begin
            base_cnt[REG_W-1:HALF] <= wdata;
            cur_cnt[REG_W-1:HALF]  <= wdata;
         end else begin
            base_cnt[HALF-1:0] <= wdata;
            cur_cnt[HALF-1:0]  <= wdata;
         end
      end else if (reload) begin
         cur_cnt <= base_cnt;
      end else if (step) begin
         cur_cnt <= cur_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode <= '0;
      else if (mode_wr) mode <= mode_in;
   end

endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
   import dmac_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int REG_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PORT_W-1:0]    io_addr,
   input  logic [BYTE_W-1:0]    io_wdata,
   input  logic                 io_wr,
   input  logic                 io_rd,
   output logic [BYTE_W-1:0]    io_rdata,
   input  logic [NCH-1:0]       step_i,
   output logic [NCH-1:0]       ch_enable,
   output logic [2*NCH-1:0]     ch_dir,
   output logic [NCH-1:0]       ch_autoinit,
   output logic [NCH-1:0]       ch_addr_dec,
   output logic [2*NCH-1:0]     ch_xfer_mode,
   output logic [REG_W*NCH-1:0] ch_cur_addr,
   output logic [REG_W*NCH-1:0] ch_cur_cnt,
   output logic [BYTE_W-1:0]    ctrl_cmd
);

   localparam int HALF = REG_W / 2;

   if (NCH < 1 || NCH > 4) begin : g_chk_nch
      $error("dmac_regbank: NCH must be 1 to 4");
   end

   ctl_strobe_t      strb;
   logic [NCH-1:0]   addr_wr, cnt_wr, tc_hit, mask_q, step_g, tc_flags;
   logic             reg_acc, ptr_hi;
   logic [REG_W-1:0] cur_addr_a [NCH];
   logic [REG_W-1:0] cur_cnt_a  [NCH];
   chan_mode_t       mode_a     [NCH];

   dmac_decode #(.NCH(NCH)) u_dec (
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .io_rd   (io_rd),
      .strb    (strb),
      .addr_wr (addr_wr),
      .cnt_wr  (cnt_wr),
      .reg_acc (reg_acc)
   );

   assign step_g = step_i & ~mask_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic mode_sel;
      assign mode_sel = strb.mode_wr && (io_wdata[1:0] == 2'(c));

      dmac_chan #(.REG_W(REG_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .addr_wr  (addr_wr[c]),
         .cnt_wr   (cnt_wr[c]),
         .hi_sel   (ptr_hi),
         .wdata    (io_wdata),
         .mode_wr  (mode_sel),
         .mode_in  (chan_mode_t'(io_wdata[BYTE_W-1:2])),
         .step     (step_g[c]),
         .cur_addr (cur_addr_a[c]),
         .cur_cnt  (cur_cnt_a[c]),
         .mode     (mode_a[c]),
         .tc_hit   (tc_hit[c])
      );

      assign ch_cur_addr[c*REG_W +: REG_W] = cur_addr_a[c];
      assign ch_cur_cnt[c*REG_W +: REG_W]  = cur_cnt_a[c];
      assign ch_dir[2*c +: 2]              = mode_a[c].dir;
      assign ch_xfer_mode[2*c +: 2]        = mode_a[c].xfer_mode;
      assign ch_autoinit[c]                = mode_a[c].auto_init;
      assign ch_addr_dec[c]                = mode_a[c].addr_dec;
   end

   assign ch_enable = ~mask_q;

   // byte pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ptr_hi <= 1'b0;
      else if (strb.mclr_wr || strb.ptr_clr_wr) ptr_hi <= 1'b0;
      else if (reg_acc)                      ptr_hi <= ~ptr_hi;
   end

   // channel masks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (strb.mclr_wr) begin
         mask_q <= '1;
      end else if (strb.unmask_all_wr) begin
         mask_q <= '0;
      end else if (strb.mask_all_wr) begin
         mask_q <= io_wdata[NCH-1:0];
      end else if (strb.mask_one_wr) begin
         for (int c = 0; c < NCH; c++)
            if (io_wdata[1:0] == 2'(c)) mask_q[c] <= io_wdata[2];
      end
   end

   // command and terminal-count status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_cmd <= '0;
         tc_flags <= '0;
      end else if (strb.mclr_wr) begin
         ctrl_cmd <= '0;
         tc_flags <= '0;
      end else begin
         if (strb.cmd_wr) ctrl_cmd <= io_wdata;
         tc_flags <= (strb.stat_rd ? '0 : tc_flags) | tc_hit;
      end
   end

   // read path
   logic [REG_W-1:0]  word_sel;
   logic [BYTE_W-1:0] stat_byte;

   always_comb begin
      word_sel = '0;
      for (int c = 0; c < NCH; c++)
         if (io_addr[2:1] == 2'(c))
            word_sel = io_addr[0] ? cur_cnt_a[c] : cur_addr_a[c];
   end

   always_comb begin
      stat_byte             = '0;
      stat_byte[NCH-1:0]    = tc_flags;
   end

   always_comb begin
      if (!io_addr[PORT_W-1])
         io_rdata = ptr_hi ? word_sel[REG_W-1:HALF] : word_sel[HALF-1:0];
      else if (io_addr == P_CMD_STAT)
         io_rdata = stat_byte;
      else
         io_rdata = '0;
   end

endmodule

// File: rtl/dmac_regbank_chk.sv
module dmac_regbank_chk #(
   parameter int NCH   = 4,
   parameter int REG_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [3:0]           io_addr,
   input logic                 io_wr,
   input logic                 io_rd,
   input logic [NCH-1:0]       step_i,
   input logic [NCH-1:0]       ch_enable,
   input logic [7:0]           ctrl_cmd,
   input logic                 ptr_hi,
   input logic [NCH-1:0]       tc_flags,
   input logic [REG_W*NCH-1:0] ch_cur_cnt
);

   p_reset_masked_r1: assert property (@(posedge clk)
      !rst_n |=> ch_enable == '0);

   p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == 4'hC) |=> !ptr_hi);

   p_ptr_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((io_wr || io_rd) && !io_addr[3]) |=> ptr_hi != $past(ptr_hi));

   p_unmask_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == 4'hE) |=> ch_enable == '1);

   p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == 4'h8 && step_i == '0) |=> tc_flags == '0);

   p_master_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == 4'hD) |=> (ch_enable == '0 && ctrl_cmd == '0 &&
                                      tc_flags == '0 && !ptr_hi));

   for (genvar c = 0; c < NCH; c++) begin : g_hold
      p_masked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (!ch_enable[c] && !(io_wr && !io_addr[3] && io_addr[2:1] == 2'(c) && io_addr[0]))
         |=> $stable(ch_cur_cnt[c*REG_W +: REG_W]));
   end

endmodule

bind dmac_regbank dmac_regbank_chk #(.NCH(NCH), .REG_W(REG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .io_addr    (io_addr),
   .io_wr      (io_wr),
   .io_rd      (io_rd),
   .step_i     (step_i),
   .ch_enable  (ch_enable),
   .ctrl_cmd   (ctrl_cmd),
   .ptr_hi     (ptr_hi),
   .tc_flags   (tc_flags),
   .ch_cur_cnt (ch_cur_cnt)
);

// File: tb/tb_dmac_regbank.sv
module tb_dmac_regbank;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       io_addr = '0;
   logic [7:0]       io_wdata = '0;
   logic             io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]       io_rdata;
   logic [NCH-1:0]   step_i = '0;
   logic [NCH-1:0]   ch_enable, ch_autoinit, ch_addr_dec;
   logic [2*NCH-1:0] ch_dir, ch_xfer_mode;
   logic [16*NCH-1:0] ch_cur_addr, ch_cur_cnt;
   logic [7:0]       ctrl_cmd;

   int total = 0;
   int bad = 0;
   logic [7:0] rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmac_regbank dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .step_i(step_i),
      .ch_enable(ch_enable), .ch_dir(ch_dir), .ch_autoinit(ch_autoinit),
      .ch_addr_dec(ch_addr_dec), .ch_xfer_mode(ch_xfer_mode),
      .ch_cur_addr(ch_cur_addr), .ch_cur_cnt(ch_cur_cnt), .ctrl_cmd(ctrl_cmd)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic pulse_step(input logic [NCH-1:0] s);
      @(negedge clk);
      step_i = s;
      @(negedge clk);
      step_i = '0;
   endtask

   function automatic logic [15:0] caddr(input int c);
      return ch_cur_addr[c*16 +: 16];
   endfunction
   function automatic logic [15:0] ccnt(input int c);
      return ch_cur_cnt[c*16 +: 16];
   endfunction

   task automatic t_reset;
      check("R1 enable", ch_enable, 0);
      check("R1 cmd", ctrl_cmd, 0);
      check("R1 addr/cnt", {ch_cur_addr, ch_cur_cnt} == '0, 1);
      check("R1 mode", {ch_dir, ch_xfer_mode, ch_autoinit, ch_addr_dec} == '0, 1);
      io_read(4'h8, rd);
      check("R1 status", rd, 0);
      io_write(4'h2, 8'hC3);       // pointer low after reset -> low byte
      check("R1 ptr low", caddr(1), 16'h00C3);
      io_write(4'hC, 8'h00);
   endtask

   task automatic t_load_read;
      io_write(4'h2, 8'h34); io_write(4'h2, 8'h12);
      check("R2 ch1 addr", caddr(1), 16'h1234);
      io_write(4'h3, 8'h05); io_write(4'h3, 8'h00);
      check("R2 ch1 cnt", ccnt(1), 16'h0005);
      io_read(4'h2, rd); check("R2 read lo", rd, 8'h34);
      io_read(4'h2, rd); check("R2 read hi", rd, 8'h12);
      io_read(4'h3, rd); check("R2 cnt lo", rd, 8'h05);
      io_read(4'h3, rd); check("R2 cnt hi", rd, 8'h00);
      check("R2 ch0 untouched", caddr(0), 16'h0000);
   endtask

   task automatic t_pointer;
      io_write(4'h0, 8'hAA);       // pointer now high
      io_write(4'hC, 8'h5A);       // any value clears
      io_write(4'h0, 8'h55); io_write(4'h0, 8'h66);
      check("R3 clear ptr", caddr(0), 16'h6655);
      io_read(4'h2, rd);           // read toggles to high
      io_write(4'h2, 8'h77);
      check("R3 read toggles", caddr(1), 16'h7734);
      io_write(4'h2, 8'h34);       // pointer low again -> low byte
      check("R3 wraps to low", caddr(1), 16'h7734);
      io_write(4'h2, 8'h12);
      check("R3 restore", caddr(1), 16'h1234);
   endtask

   task automatic t_mask;
      io_write(4'hA, 8'h01); check("R4 unmask ch1", ch_enable, 4'b0010);
      io_write(4'hA, 8'h06); check("R4 mask ch2 noop", ch_enable, 4'b0010);
      io_write(4'hA, 8'h03); check("R4 unmask ch3", ch_enable, 4'b1010);
      io_write(4'hA, 8'h05); check("R4 mask ch1", ch_enable, 4'b1000);
      io_write(4'hE, 8'h00); check("R5 unmask all", ch_enable, 4'b1111);
      io_write(4'hF, 8'h0A); check("R5 write all", ch_enable, 4'b0101);
      io_write(4'hF, 8'h0F); check("R5 mask all", ch_enable, 4'b0000);
   endtask

   task automatic t_mode;
      io_write(4'hB, 8'hD6);       // ch2: cascade, autoinit, dir 01
      check("R6 ch2 dir", ch_dir[5:4], 2'b01);
      check("R6 ch2 auto", ch_autoinit[2], 1);
      check("R6 ch2 dec", ch_addr_dec[2], 0);
      check("R6 ch2 mode", ch_xfer_mode[5:4], 2'b11);
      io_write(4'hB, 8'h6B);       // ch3: single, dec, dir 10
      check("R6 ch3 fields", {ch_xfer_mode[7:6], ch_addr_dec[3], ch_autoinit[3], ch_dir[7:6]},
            {2'b01, 1'b1, 1'b0, 2'b10});
      check("R6 ch2 kept", ch_xfer_mode[5:4], 2'b11);
   endtask

   task automatic t_step;
      io_write(4'h3, 8'h02); io_write(4'h3, 8'h00);  // ch1 cnt = 2
      io_write(4'hB, 8'h45);                         // ch1 single, inc, no auto
      io_write(4'hE, 8'h00);
      pulse_step(4'b0010);
      check("R9 step addr", caddr(1), 16'h1235);
      check("R9 step cnt", ccnt(1), 16'h0001);
      pulse_step(4'b0010);
      pulse_step(4'b0010);
      check("R9 wrap cnt", ccnt(1), 16'hFFFF);
      check("R9 wrap addr", caddr(1), 16'h1237);
      io_read(4'h8, rd); check("R7 status tc1", rd, 8'h02);
      io_read(4'h8, rd); check("R7 status cleared", rd, 8'h00);
      io_write(4'hA, 8'h05);
      pulse_step(4'b0010);
      check("R9 masked addr", caddr(1), 16'h1237);
      check("R9 masked cnt", ccnt(1), 16'hFFFF);
   endtask

   task automatic t_autoinit;
      io_write(4'hB, 8'h77);                         // ch3 auto, dec, dir 01
      io_write(4'h6, 8'h00); io_write(4'h6, 8'h01);
      io_write(4'h7, 8'h01); io_write(4'h7, 8'h00);
      pulse_step(4'b1000);
      check("R9 dec addr", caddr(3), 16'h00FF);
      check("R9 dec cnt", ccnt(3), 16'h0000);
      pulse_step(4'b1000);
      check("R9 reload addr", caddr(3), 16'h0100);
      check("R9 reload cnt", ccnt(3), 16'h0001);
      io_read(4'h8, rd); check("R7 status tc3", rd, 8'h08);
   endtask

   task automatic t_cmd_mclr;
      io_write(4'h8, 8'hA5);
      check("R7 cmd", ctrl_cmd, 8'hA5);
      pulse_step(4'b1000); pulse_step(4'b1000);      // tc on ch3 again
      io_write(4'h0, 8'h11);                         // pointer high
      io_write(4'hD, 8'h00);
      check("R8 masks", ch_enable, 4'b0000);
      check("R8 cmd", ctrl_cmd, 8'h00);
      io_read(4'h8, rd); check("R8 status", rd, 8'h00);
      io_write(4'h0, 8'h22);
      check("R8 ptr low", caddr(0), 16'h6622);
      io_write(4'hC, 8'h00);
      check("R8 addr kept", caddr(1), 16'h1237);
      check("R8 mode kept", ch_xfer_mode[5:4], 2'b11);
      io_read(4'hD, rd); check("R8 temp", rd, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_read();
      t_pointer();
      t_mask();
      t_mode();
      t_step();
      t_autoinit();
      t_cmd_mclr();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule